// File: doc/BRIEF.md
# High-Speed Lane Burst Sequencer

This block drives one data lane of a source-synchronous camera link transmitter. It walks the lane through a burst. The lane leaves the low-power stop state and passes through two low-power request levels. It then drives a run of high-speed zeros and one sync byte, followed by the payload bytes. A trail phase drives the inverted last bit, and the lane returns to the stop state. The outputs are the two single-ended low-power line levels, a high-speed enable and the byte handed to a serializer.

Each phase length is a configuration input counted in reference-clock cycles. The block checks every length against a window at the moment a request arrives. The window is computed at elaboration from the reference clock period and the unit interval, and each limit combines a fixed nanosecond term with a term in unit intervals. A request made with an illegal setting starts no burst and sets a sticky error flag. If the payload stream stalls in the middle of a burst, the block closes the burst at once through the trail phase and flags an underflow.

Top module: `lane_burst_seq`

## Requirements
- R1: After reset, and whenever no burst is in progress, lp_p=1, lp_n=1 (stop state), hs_en=0, busy=0 and in_ready=0; cfg_err and underflow are 0 after reset.
- R2: A request accepted on a clock edge makes busy high from the next cycle. The lane then shows lp_p=0/lp_n=1 for cfg_lpx cycles, followed by lp_p=0/lp_n=0 for cfg_prep cycles. The phases always occur in that order, and no other line state appears before high speed starts.
- R3: High speed starts with hs_en=1 and hs_byte=8'h00 for cfg_zero cycles, followed by exactly one cycle with hs_byte=8'hB8 (sync).
- R4: in_ready is high in the sync cycle and in every payload cycle whose byte was not flagged last. Each byte accepted with in_valid&in_ready appears on hs_byte in the following cycle, in order.
- R5: After the last payload byte, hs_byte holds cfg_trail cycles of eight copies of the inverse of bit 7 of the last high-speed byte. Bit 7 is the last bit serialized, because the serializer is LSB first. hs_en then drops.
- R6: After the trail, the lane is in the stop state with busy=1 for cfg_exit cycles, then busy falls.
- R7: If in_valid is low in a cycle where in_ready is high, the next cycle is the first trail cycle and underflow is set. The trail fill follows the last byte actually shown, which is the sync byte when no payload was sent. underflow is cleared when the next request is accepted.
- R8: With the default parameters (8000 ps reference period, 3333 ps unit interval), the legal windows in cycles are: cfg_lpx>=7; 7<=cfg_prep<=13; cfg_prep+cfg_zero>=23; 10<=cfg_trail<=18; cfg_exit>=13. Settings on these boundaries are accepted.
- R9: A request made while any setting is outside its window starts no burst (busy stays 0) and sets cfg_err. cfg_err stays set until reset, and while it is set every later request is refused.
- R10: A request made while busy is high has no effect: no second burst follows the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Burst request, sampled while idle |
| cfg_lpx | input | CW | LP-01 request phase length in cycles |
| cfg_prep | input | CW | LP-00 prepare phase length in cycles |
| cfg_zero | input | CW | HS-0 zero phase length in cycles |
| cfg_trail | input | CW | Trail phase length in cycles |
| cfg_exit | input | CW | Post-burst stop-state hold in cycles |
| in_valid | input | 1 | Payload byte valid |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Marks the final payload byte |
| in_ready | output | 1 | Payload byte accepted this cycle when valid |
| lp_p | output | 1 | Low-power level of the positive wire |
| lp_n | output | 1 | Low-power level of the negative wire |
| hs_en | output | 1 | High-speed driver enable |
| hs_byte | output | 8 | Byte to the serializer, zero when hs_en is low |
| busy | output | 1 | Burst in progress including exit hold |
| underflow | output | 1 | Last burst ended on a payload stall |
| cfg_err | output | 1 | Sticky: request seen with an illegal setting |

## Verification
Bursts are run with several mixes of phase lengths. Some sit on the lower edge of every window and some on the upper prepare and trail limits, so an off-by-one in any phase counter shows in the measured cycle counts. Payload lengths of one, three and six bytes use seeds whose last byte has bit 7 set or clear, which separates a trail fill of all ones from all zeros. Two stalls are tried, one in mid payload and one in the sync cycle, to check how underflow closes a burst. Each window limit is broken once by one cycle, together with a request during a burst, to tell refused starts from ignored ones.

// File: rtl/lane_burst_seq.sv
module lane_burst_seq #(
  parameter int REF_PS = 8000,
  parameter int UI_PS  = 3333,
  parameter int CW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [CW-1:0] cfg_lpx,
  input  logic [CW-1:0] cfg_prep,
  input  logic [CW-1:0] cfg_zero,
  input  logic [CW-1:0] cfg_trail,
  input  logic [CW-1:0] cfg_exit,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  output logic          in_ready,
  output logic          lp_p,
  output logic          lp_n,
  output logic          hs_en,
  output logic [7:0]    hs_byte,
  output logic          busy,
  output logic          underflow,
  output logic          cfg_err
);

  localparam int LPX_MIN   = (50000 + REF_PS - 1) / REF_PS;
  localparam int PREP_MIN  = (40000 + 4 * UI_PS + REF_PS - 1) / REF_PS;
  localparam int PREP_MAX  = (85000 + 6 * UI_PS) / REF_PS;
  localparam int PZ_MIN    = (145000 + 10 * UI_PS + REF_PS - 1) / REF_PS;
  localparam int TRAIL_PS  = (8 * UI_PS > 60000 + 4 * UI_PS) ? 8 * UI_PS : 60000 + 4 * UI_PS;
  localparam int TRAIL_MIN = (TRAIL_PS + REF_PS - 1) / REF_PS;
  localparam int TRAIL_MAX = (105000 + 12 * UI_PS) / REF_PS;
  localparam int EXIT_MIN  = (100000 + REF_PS - 1) / REF_PS;
  localparam logic [7:0] SYNC_BYTE = 8'hB8;

  typedef enum logic [2:0] {S_IDLE, S_RQST, S_PREP, S_ZERO, S_SYNC, S_DATA, S_TRAIL, S_EXIT} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [7:0]    byte_q;
  logic          last_q;
  logic          cfg_bad;
  logic          cnt_done;
  logic [7:0]    fill;

  assign cfg_bad = (int'(cfg_lpx) < LPX_MIN)
                || (int'(cfg_prep) < PREP_MIN) || (int'(cfg_prep) > PREP_MAX)
                || (int'(cfg_prep) + int'(cfg_zero) < PZ_MIN)
                || (int'(cfg_trail) < TRAIL_MIN) || (int'(cfg_trail) > TRAIL_MAX)
                || (int'(cfg_exit) < EXIT_MIN);

  assign cnt_done = (cnt == '0);
  assign fill     = {8{~byte_q[7]}};

  assign lp_p     = (state == S_IDLE) || (state == S_EXIT);
  assign lp_n     = (state == S_IDLE) || (state == S_EXIT) || (state == S_RQST);
  assign hs_en    = (state == S_ZERO) || (state == S_SYNC) || (state == S_DATA) || (state == S_TRAIL);
  assign hs_byte  = hs_en ? byte_q : 8'h00;
  assign busy     = (state != S_IDLE);
  assign in_ready = (state == S_SYNC) || ((state == S_DATA) && !last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      byte_q    <= 8'h00;
      last_q    <= 1'b0;
      underflow <= 1'b0;
      cfg_err   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (req) begin
            if (cfg_bad || cfg_err) begin
              cfg_err <= 1'b1;
            end else begin
              state     <= S_RQST;
              cnt       <= cfg_lpx - CW'(1);
              underflow <= 1'b0;
              last_q    <= 1'b0;
            end
          end
        end
        S_RQST: begin
          if (cnt_done) begin
            state <= S_PREP;
            cnt   <= cfg_prep - CW'(1);
          end else cnt <= cnt - CW'(1);
        end
        S_PREP: begin
          if (cnt_done) begin
            state  <= S_ZERO;
            cnt    <= cfg_zero - CW'(1);
            byte_q <= 8'h00;
          end else cnt <= cnt - CW'(1);
        end
        S_ZERO: begin
          if (cnt_done) begin
            state  <= S_SYNC;
            byte_q <= SYNC_BYTE;
          end else cnt <= cnt - CW'(1);
        end
        S_SYNC, S_DATA: begin
          if (in_ready && in_valid) begin
            state  <= S_DATA;
            byte_q <= in_data;
            last_q <= in_last;
          end else begin
            if (in_ready) underflow <= 1'b1;
            state  <= S_TRAIL;
            byte_q <= fill;
            cnt    <= cfg_trail - CW'(1);
          end
        end
        S_TRAIL: begin
          if (cnt_done) begin
            state <= S_EXIT;
            cnt   <= cfg_exit - CW'(1);
          end else cnt <= cnt - CW'(1);
        end
        S_EXIT: begin
          if (cnt_done) state <= S_IDLE;
          else cnt <= cnt - CW'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r1_idle_stop_state: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (lp_p && lp_n && !hs_en && !in_ready));

  a_r2_hs_after_lp00: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> $past(!lp_p && !lp_n));

  a_r3_first_hs_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> (hs_byte == 8'h00));

  a_r4_ready_only_in_hs: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> hs_en);

  a_r5_trail_uniform: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_en) |-> ($past(hs_byte) == 8'h00 || $past(hs_byte) == 8'hFF));

  a_r6_exit_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(lp_p && lp_n && !hs_en));

  a_r7_underflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underflow) |-> $past(in_ready && !in_valid));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

endmodule

// File: tb/lane_burst_seq_tb.sv
`timescale 1ns/1ps
module lane_burst_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic [7:0] cfg_lpx = 8'd7, cfg_prep = 8'd7, cfg_zero = 8'd16, cfg_trail = 8'd10, cfg_exit = 8'd13;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_last = 1'b0;
  logic       in_ready, lp_p, lp_n, hs_en, busy, underflow, cfg_err;
  logic [7:0] hs_byte;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  lane_burst_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req(req),
    .cfg_lpx(cfg_lpx), .cfg_prep(cfg_prep), .cfg_zero(cfg_zero),
    .cfg_trail(cfg_trail), .cfg_exit(cfg_exit),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .lp_p(lp_p), .lp_n(lp_n), .hs_en(hs_en), .hs_byte(hs_byte),
    .busy(busy), .underflow(underflow), .cfg_err(cfg_err)
  );

  always #4 clk = ~clk;

  // fields: lpx, prep, zero, trail, exit, bytes, stall index (FF none), seed
  localparam logic [63:0] VEC [5] = '{
    {8'd7,  8'd7,  8'd16, 8'd10, 8'd13, 8'd3, 8'hFF, 8'h11},
    {8'd10, 8'd13, 8'd10, 8'd18, 8'd20, 8'd1, 8'hFF, 8'h90},
    {8'd8,  8'd9,  8'd14, 8'd12, 8'd13, 8'd4, 8'd2,  8'h05},
    {8'd7,  8'd8,  8'd20, 8'd10, 8'd15, 8'd6, 8'hFF, 8'hC3},
    {8'd9,  8'd10, 8'd13, 8'd14, 8'd13, 8'd2, 8'd0,  8'h20}
  };

  // fields: lpx, prep, zero, trail, exit; each one cycle outside a window
  localparam logic [39:0] BAD [7] = '{
    {8'd6, 8'd7,  8'd16, 8'd10, 8'd13},
    {8'd7, 8'd6,  8'd17, 8'd10, 8'd13},
    {8'd7, 8'd14, 8'd9,  8'd10, 8'd13},
    {8'd7, 8'd7,  8'd15, 8'd10, 8'd13},
    {8'd7, 8'd7,  8'd16, 8'd9,  8'd13},
    {8'd7, 8'd7,  8'd16, 8'd19, 8'd13},
    {8'd7, 8'd7,  8'd16, 8'd10, 8'd12}
  };

  function automatic logic [7:0] byte_at(input logic [7:0] seed, input int k);
    return seed + 8'(k * 53);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req = 1'b0;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_req();
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic run_burst(input logic [63:0] v);
    int n, gap, nexp, c01, c00, cz, ct, cx, pidx, sent, rank, r;
    bit sync, ord_ok, data_ok, fill_ok, uf_exp;
    logic [7:0] seed, lastb, fillv;
    n = int'(v[23:16]);
    gap = int'(v[15:8]);
    seed = v[7:0];
    nexp = (gap < n) ? gap : n;
    uf_exp = (gap < n);
    lastb = (nexp > 0) ? byte_at(seed, nexp - 1) : 8'hB8;
    fillv = {8{~lastb[7]}};
    c01 = 0; c00 = 0; cz = 0; ct = 0; cx = 0; pidx = 0; sent = 0; rank = 0;
    sync = 0; ord_ok = 1; data_ok = 1; fill_ok = 1;
    @(negedge clk);
    cfg_lpx = v[63:56]; cfg_prep = v[55:48]; cfg_zero = v[47:40];
    cfg_trail = v[39:32]; cfg_exit = v[31:24];
    req = 1'b1;
    for (int cyc = 0; cyc < 1000; cyc++) begin
      @(negedge clk);
      req = 1'b0;
      if (!busy) break;
      if (!hs_en && !lp_p && lp_n) begin r = 0; c01++; end
      else if (!hs_en && !lp_p && !lp_n) begin r = 1; c00++; end
      else if (hs_en && !sync) begin
        if (hs_byte == 8'hB8) begin sync = 1; r = 3; end
        else begin r = 2; cz++; if (hs_byte != 8'h00) data_ok = 0; end
      end
      else if (hs_en && pidx < nexp) begin
        r = 4;
        if (hs_byte != byte_at(seed, pidx)) data_ok = 0;
        pidx++;
      end
      else if (hs_en) begin r = 5; ct++; if (hs_byte != fillv) fill_ok = 0; end
      else if (lp_p && lp_n) begin r = 6; cx++; end
      else begin r = 9; ord_ok = 0; end
      if (r < rank) ord_ok = 0;
      rank = r;
      if (in_ready && sent < n && sent != gap) begin
        in_valid = 1'b1;
        in_data = byte_at(seed, sent);
        in_last = (sent == n - 1);
        sent++;
      end else begin
        in_valid = 1'b0;
        in_last = 1'b0;
      end
    end
    in_valid = 1'b0;
    in_last = 1'b0;
    chk(c01 > 0, "R8", "in-window setting accepted", c01, int'(v[63:56]));
    chk(c01 == int'(v[63:56]), "R2", "LP-01 cycles", c01, int'(v[63:56]));
    chk(c00 == int'(v[55:48]), "R2", "LP-00 cycles", c00, int'(v[55:48]));
    chk(ord_ok, "R2", "phase order", ord_ok, 1);
    chk(cz == int'(v[47:40]), "R3", "HS-0 cycles", cz, int'(v[47:40]));
    chk(sync, "R3", "sync byte seen", sync, 1);
    chk(pidx == nexp && data_ok, "R4", "payload bytes in order", pidx, nexp);
    chk(ct == int'(v[39:32]), "R5", "trail cycles", ct, int'(v[39:32]));
    chk(fill_ok, "R5", "trail fill value", fill_ok, 1);
    chk(cx == int'(v[31:24]), "R6", "exit hold cycles", cx, int'(v[31:24]));
    chk(underflow == uf_exp, "R7", "underflow flag", underflow, uf_exp);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int w;
    do_reset();
    chk(lp_p && lp_n, "R1", "stop state after reset", {lp_p, lp_n}, 3);
    chk(!hs_en && !busy, "R1", "hs_en/busy after reset", {hs_en, busy}, 0);
    chk(!in_ready, "R1", "in_ready after reset", in_ready, 0);
    chk(!underflow && !cfg_err, "R1", "flags after reset", {underflow, cfg_err}, 0);

    for (int i = 0; i < 5; i++) run_burst(VEC[i]);

    // R10: a request raised during a burst is ignored
    cfg_lpx = 8'd7; cfg_prep = 8'd7; cfg_zero = 8'd16; cfg_trail = 8'd10; cfg_exit = 8'd13;
    pulse_req();
    repeat (10) @(negedge clk);
    chk(busy, "R10", "burst in progress", busy, 1);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    w = 0;
    while (busy && w < 500) begin @(negedge clk); w++; end
    repeat (4) begin
      chk(!busy && lp_p && lp_n, "R10", "no second burst", busy, 0);
      @(negedge clk);
    end

    // R8/R9: each out-of-window setting refuses the start
    for (int i = 0; i < 7; i++) begin
      do_reset();
      {cfg_lpx, cfg_prep, cfg_zero, cfg_trail, cfg_exit} = BAD[i];
      pulse_req();
      chk(!busy && lp_p && lp_n, "R9", "bad setting refused", busy, 0);
      chk(cfg_err, "R8", "window violation flagged", cfg_err, 1);
    end
    cfg_lpx = 8'd7; cfg_prep = 8'd7; cfg_zero = 8'd16; cfg_trail = 8'd10; cfg_exit = 8'd13;
    pulse_req();
    chk(!busy, "R9", "sticky error blocks good request", busy, 0);
    chk(cfg_err, "R9", "error stays set", cfg_err, 1);
    do_reset();
    chk(!cfg_err, "R1", "reset clears error", cfg_err, 0);
    pulse_req();
    chk(busy, "R9", "good request after reset starts", busy, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule